// File: doc/BRIEF.md
# Interrupt Acceptance Sequencer

This block models how a small processor core takes an interrupt. A request arrives together with its source class, a sub-code, a priority level, the parity of its vector address, the parity of the stack pointer and the current data-bus width. The block latches all of these when the request is taken. It then waits for the instruction in flight to retire. After that it counts out the cycles of the interrupt entry sequence. When the count ends it loads the new interrupt priority level (IPL) and pulses a start strobe for the first handler instruction. Register stacking and the vector fetch are not carried out. Only their duration is modelled.

The length of the entry sequence depends on the captured conditions:

- With a byte-wide bus the base is 20 cycles.
- With a 16-bit bus the base is 18 cycles, plus one for an odd vector address and one for an odd stack pointer.
- The debug source adds two cycles. Address-match and single-step sources add one cycle each.

The state machine has four states:

- `ST_IDLE`: waiting for a request.
- `ST_DRAIN`: waiting for the instruction in flight to retire.
- `ST_STACK`: counting the entry sequence.
- `ST_LAUNCH`: the one-cycle start state.

Its transitions are:

- `ST_IDLE`→`ST_DRAIN` when a request is taken.
- `ST_DRAIN`→`ST_STACK` on the instruction-complete strobe.
- `ST_STACK`→`ST_LAUNCH` when the counter holds its last value.
- `ST_LAUNCH`→`ST_IDLE` unconditionally.

Top module: `irq_accept_seq`

## Requirements
- R1: After reset `busy` is 0, `ipl` is 0 and `handler_start` is 0.
- R2: A request (`req_valid`=1) is taken only while `busy` is 0, and `busy` reads 1 in the cycle after the request is taken. Requests presented while `busy` is 1 are dropped: they are not queued and they do not change the outcome.
- R3: The sequence starts only on the first `instr_done`=1 after acceptance, however many cycles that takes (30 or more). `instr_done` has no effect while idle. `handler_start` stays 0 during the wait.
- R4: With `bus_narrow`=0, the sequence is 18 cycles when both `vec_odd` and `sp_odd` are 0, 19 cycles when exactly one of them is 1, and 20 cycles when both are 1.
- R5: With `bus_narrow`=1 the base sequence is 20 cycles, whatever the parities.
- R6: With `req_class`=2 (quiet non-maskable), `req_sub` adds cycles: 0 (software) adds 0, 1 (address match) adds 1, 2 (single step) adds 1, and 3 (debug) adds 2. For other classes `req_sub` is ignored.
- R7: `handler_start` is 1 for exactly one cycle, and that cycle is N cycles after the cycle in which `instr_done` was taken, where N is the sequence length. `busy` is 0 in the following cycle.
- R8: With `req_class`=0 (maskable), `ipl` takes the captured `req_level` in the `handler_start` cycle.
- R9: With `req_class`=1 (urgent: oscillation stop, watchdog or NMI), `ipl` becomes 7 in the `handler_start` cycle.
- R10: With `req_class`=2 (or the reserved code 3), `ipl` is unchanged. `ipl` never changes outside a `handler_start` cycle.
- R11: Class, sub-code, level, parities and bus width are sampled at acceptance. Changes to them while `busy` is 1 do not alter the length or the IPL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Interrupt request |
| req_class | input | 2 | 0 maskable, 1 urgent, 2 quiet non-maskable, 3 reserved |
| req_sub | input | 2 | Extra-cycle selector for the quiet class |
| req_level | input | IPL_W | Priority level of a maskable request |
| vec_odd | input | 1 | Vector address bit 0 |
| sp_odd | input | 1 | Stack pointer bit 0 |
| bus_narrow | input | 1 | 1 = 8-bit data bus, 0 = 16-bit |
| instr_done | input | 1 | Executing instruction has retired |
| busy | output | 1 | Acceptance in progress |
| ipl | output | IPL_W | Current interrupt priority level |
| handler_start | output | 1 | One-cycle strobe: first handler instruction may begin |

## Verification
The hardest case to reach from the ports is proving that the sampled conditions are held. A flawed design would still give the right answer if the inputs stayed put. The stimulus therefore keeps re-asserting `req_valid` while the block waits for `instr_done`, with the class, level, parities and bus width all changed to values that would give a different length and IPL. A sweep of every combination of bus width, parity and class with sub-code then compares the measured start delay and resulting IPL against a model kept in the bench.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    typedef enum logic [1:0] {
        SRC_MASKABLE = 2'd0,
        SRC_URGENT   = 2'd1,
        SRC_QUIET    = 2'd2,
        SRC_RSVD     = 2'd3
    } src_class_e;

    typedef enum logic [1:0] {
        SUB_PLAIN       = 2'd0,
        SUB_ADDR_MATCH  = 2'd1,
        SUB_SINGLE_STEP = 2'd2,
        SUB_DEBUG       = 2'd3
    } src_sub_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DRAIN  = 2'd1,
        ST_STACK  = 2'd2,
        ST_LAUNCH = 2'd3
    } seq_state_e;

endpackage

// File: rtl/irq_req_capture.sv
module irq_req_capture
    import irq_seq_pkg::*;
#(
    parameter int IPL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             busy,
    input  logic [1:0]       req_class,
    input  logic [1:0]       req_sub,
    input  logic [IPL_W-1:0] req_level,
    input  logic             vec_odd,
    input  logic             sp_odd,
    input  logic             bus_narrow,
    output src_class_e       snap_class,
    output src_sub_e         snap_sub,
    output logic [IPL_W-1:0] snap_level,
    output logic             snap_vec_odd,
    output logic             snap_sp_odd,
    output logic             snap_narrow
);

    // Snapshot of the request conditions, loaded only at acceptance.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_class   <= SRC_MASKABLE;
            snap_sub     <= SUB_PLAIN;
            snap_level   <= '0;
            snap_vec_odd <= 1'b0;
            snap_sp_odd  <= 1'b0;
            snap_narrow  <= 1'b0;
        end else if (accept) begin
            snap_class   <= src_class_e'(req_class);
            snap_sub     <= src_sub_e'(req_sub);
            snap_level   <= req_level;
            snap_vec_odd <= vec_odd;
            snap_sp_odd  <= sp_odd;
            snap_narrow  <= bus_narrow;
        end
    end

    // R11: snapshot is frozen for as long as the block stays busy
    assert_snap_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |->
            ($stable(snap_class) && $stable(snap_sub) && $stable(snap_level) &&
             $stable(snap_vec_odd) && $stable(snap_sp_odd) && $stable(snap_narrow)));

endmodule

// File: rtl/irq_cycle_calc.sv
module irq_cycle_calc
    import irq_seq_pkg::*;
#(
    parameter int BASE_WIDE    = 18,
    parameter int BASE_NARROW  = 20,
    parameter int EXTRA_SIMPLE = 1,
    parameter int EXTRA_DEBUG  = 2,
    parameter int CNT_W        = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  src_class_e       snap_class,
    input  src_sub_e         snap_sub,
    input  logic             snap_vec_odd,
    input  logic             snap_sp_odd,
    input  logic             snap_narrow,
    output logic [CNT_W-1:0] seq_len
);

    logic [CNT_W-1:0] base_len;
    logic [CNT_W-1:0] extra_len;

    // Base length: a byte bus hides the alignment penalty, a 16-bit bus pays per odd address.
    always_comb begin
        if (snap_narrow) begin
            base_len = CNT_W'(BASE_NARROW);
        end else begin
            base_len = CNT_W'(BASE_WIDE) + CNT_W'(snap_vec_odd) + CNT_W'(snap_sp_odd);
        end
    end

    // Source-specific extra cycles apply only to the quiet non-maskable class.
    always_comb begin
        extra_len = '0;
        if (snap_class == SRC_QUIET) begin
            unique case (snap_sub)
                SUB_PLAIN:       extra_len = '0;
                SUB_ADDR_MATCH:  extra_len = CNT_W'(EXTRA_SIMPLE);
                SUB_SINGLE_STEP: extra_len = CNT_W'(EXTRA_SIMPLE);
                SUB_DEBUG:       extra_len = CNT_W'(EXTRA_DEBUG);
            endcase
        end
    end

    assign seq_len = base_len + extra_len;

    // R4: the computed length always lies in the legal window
    assert_len_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_len >= CNT_W'(BASE_WIDE)) &&
        (seq_len <= CNT_W'(BASE_NARROW + EXTRA_DEBUG)));

endmodule

// File: rtl/irq_ipl_update.sv
module irq_ipl_update
    import irq_seq_pkg::*;
#(
    parameter int IPL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  src_class_e       snap_class,
    input  logic [IPL_W-1:0] snap_level,
    output logic [IPL_W-1:0] ipl
);

    localparam logic [IPL_W-1:0] IPL_TOP = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ipl <= '0;
        end else if (load) begin
            unique case (snap_class)
                SRC_MASKABLE: ipl <= snap_level;
                SRC_URGENT:   ipl <= IPL_TOP;
                SRC_QUIET:    ipl <= ipl;
                SRC_RSVD:     ipl <= ipl;
            endcase
        end
    end

endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
    import irq_seq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             instr_done,
    input  logic [CNT_W-1:0] seq_len,
    output logic             accept,
    output logic             load_ipl,
    output logic             busy,
    output logic             handler_start
);

    seq_state_e       state;
    seq_state_e       state_nx;
    logic [CNT_W-1:0] cnt;
    logic             last_cycle;

    assign last_cycle = (cnt == CNT_W'(1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (req_valid)  state_nx = ST_DRAIN;
            ST_DRAIN:  if (instr_done) state_nx = ST_STACK;
            ST_STACK:  if (last_cycle) state_nx = ST_LAUNCH;
            ST_LAUNCH: state_nx = ST_IDLE;
        endcase
    end

    // Sequence down-counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (state == ST_DRAIN && instr_done) begin
            cnt <= seq_len;
        end else if (state == ST_STACK) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    // Outputs
    always_comb begin
        accept        = 1'b0;
        load_ipl      = 1'b0;
        busy          = 1'b1;
        handler_start = 1'b0;
        unique case (state)
            ST_IDLE: begin
                busy   = 1'b0;
                accept = req_valid;
            end
            ST_DRAIN: ;
            ST_STACK:  load_ipl = last_cycle;
            ST_LAUNCH: handler_start = 1'b1;
        endcase
    end

    // R4: the counter never sits at zero while sequencing
    assert_cnt_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STACK) |-> (cnt != '0));

    // R3: leaving the drain state requires the completion strobe
    assert_drain_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN && !instr_done) |=> (state == ST_DRAIN));

endmodule

// File: rtl/irq_accept_seq.sv
module irq_accept_seq
    import irq_seq_pkg::*;
#(
    parameter int IPL_W        = 3,
    parameter int BASE_WIDE    = 18,
    parameter int BASE_NARROW  = 20,
    parameter int EXTRA_SIMPLE = 1,
    parameter int EXTRA_DEBUG  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_class,
    input  logic [1:0]       req_sub,
    input  logic [IPL_W-1:0] req_level,
    input  logic             vec_odd,
    input  logic             sp_odd,
    input  logic             bus_narrow,
    input  logic             instr_done,
    output logic             busy,
    output logic [IPL_W-1:0] ipl,
    output logic             handler_start
);

    localparam int WIDE_MAX = BASE_WIDE + 2;
    localparam int BASE_MAX = (WIDE_MAX > BASE_NARROW) ? WIDE_MAX : BASE_NARROW;
    localparam int LEN_MAX  = BASE_MAX + EXTRA_DEBUG;
    localparam int CNT_W    = $clog2(LEN_MAX + 1);

    logic             accept;
    logic             load_ipl;
    src_class_e       snap_class;
    src_sub_e         snap_sub;
    logic [IPL_W-1:0] snap_level;
    logic             snap_vec_odd;
    logic             snap_sp_odd;
    logic             snap_narrow;
    logic [CNT_W-1:0] seq_len;

    irq_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .instr_done    (instr_done),
        .seq_len       (seq_len),
        .accept        (accept),
        .load_ipl      (load_ipl),
        .busy          (busy),
        .handler_start (handler_start)
    );

    irq_req_capture #(.IPL_W(IPL_W)) u_cap (
        .clk          (clk),
        .rst_n        (rst_n),
        .accept       (accept),
        .busy         (busy),
        .req_class    (req_class),
        .req_sub      (req_sub),
        .req_level    (req_level),
        .vec_odd      (vec_odd),
        .sp_odd       (sp_odd),
        .bus_narrow   (bus_narrow),
        .snap_class   (snap_class),
        .snap_sub     (snap_sub),
        .snap_level   (snap_level),
        .snap_vec_odd (snap_vec_odd),
        .snap_sp_odd  (snap_sp_odd),
        .snap_narrow  (snap_narrow)
    );

    irq_cycle_calc #(
        .BASE_WIDE    (BASE_WIDE),
        .BASE_NARROW  (BASE_NARROW),
        .EXTRA_SIMPLE (EXTRA_SIMPLE),
        .EXTRA_DEBUG  (EXTRA_DEBUG),
        .CNT_W        (CNT_W)
    ) u_calc (
        .clk          (clk),
        .rst_n        (rst_n),
        .snap_class   (snap_class),
        .snap_sub     (snap_sub),
        .snap_vec_odd (snap_vec_odd),
        .snap_sp_odd  (snap_sp_odd),
        .snap_narrow  (snap_narrow),
        .seq_len      (seq_len)
    );

    irq_ipl_update #(.IPL_W(IPL_W)) u_ipl (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load_ipl),
        .snap_class (snap_class),
        .snap_level (snap_level),
        .ipl        (ipl)
    );

    // R7: start strobe lasts a single cycle
    assert_start_one_shot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        handler_start |=> !handler_start);

    // R7: block is free again right after the strobe
    assert_idle_after_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        handler_start |=> !busy);

    // R10: the priority level only moves together with the strobe
    assert_ipl_moves_at_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ipl) |-> handler_start);

    // R8: maskable source installs its own level
    assert_mask_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (handler_start && snap_class == SRC_MASKABLE) |-> (ipl == snap_level));

    // R9: urgent source raises the level to the top
    assert_urgent_top_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (handler_start && snap_class == SRC_URGENT) |-> (ipl == '1));

    // R2: strobe only while the block was busy in the previous cycle
    assert_start_needs_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        handler_start |-> $past(busy));

endmodule

// File: tb/sim_irq_accept_seq.sv
module sim_irq_accept_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_class = 2'd0;
    logic [1:0] req_sub = 2'd0;
    logic [2:0] req_level = 3'd0;
    logic       vec_odd = 1'b0;
    logic       sp_odd = 1'b0;
    logic       bus_narrow = 1'b0;
    logic       instr_done = 1'b0;
    logic       busy;
    logic [2:0] ipl;
    logic       handler_start;

    int n_checks = 0;
    int n_fail   = 0;
    int model_ipl = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    irq_accept_seq u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_class     (req_class),
        .req_sub       (req_sub),
        .req_level     (req_level),
        .vec_odd       (vec_odd),
        .sp_odd        (sp_odd),
        .bus_narrow    (bus_narrow),
        .instr_done    (instr_done),
        .busy          (busy),
        .ipl           (ipl),
        .handler_start (handler_start)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_len(input int cls, input int sub, input int vo, input int so,
                                   input int nar);
        int len;
        len = nar ? 20 : 18 + vo + so;
        if (cls == 2) len += (sub == 3) ? 2 : (sub == 0 ? 0 : 1);
        return len;
    endfunction

    // One complete acceptance; disturb re-drives conflicting requests while waiting.
    task automatic run_case(input int cls, input int sub, input int lvl, input int vo,
                            input int so, input int nar, input int waitc, input bit disturb,
                            input string tag);
        int edges;
        int early;
        int len;
        len = exp_len(cls, sub, vo, so, nar);
        @(negedge clk);
        req_valid = 1'b1; req_class = 2'(cls); req_sub = 2'(sub); req_level = 3'(lvl);
        vec_odd = vo[0]; sp_odd = so[0]; bus_narrow = nar[0];
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " R2 busy after accept"}, int'(busy), 1);
        early = 0;
        for (int w = 0; w < waitc; w++) begin
            if (disturb) begin
                req_valid = 1'b1; req_class = 2'(cls == 1 ? 0 : 1); req_sub = ~2'(sub);
                req_level = ~3'(lvl); vec_odd = ~vo[0]; sp_odd = ~so[0]; bus_narrow = ~nar[0];
            end
            @(negedge clk);
            if (handler_start) early++;
        end
        chk({tag, " R3 no start during wait"}, early, 0);
        req_valid = 1'b0;
        instr_done = 1'b1;
        @(negedge clk);
        instr_done = 1'b0;
        edges = 1;
        while (!handler_start && edges < 80) begin
            @(negedge clk);
            edges++;
        end
        chk({tag, " R4/R5/R6 sequence length"}, edges - 1, len);
        if (cls == 0) model_ipl = lvl;
        else if (cls == 1) model_ipl = 7;
        chk({tag, " R8/R9/R10 ipl"}, int'(ipl), model_ipl);
        @(negedge clk);
        chk({tag, " R7 one-shot start"}, int'(handler_start), 0);
        chk({tag, " R7 busy released"}, int'(busy), 0);
    endtask

    task automatic t_reset;
        chk("R1 busy", int'(busy), 0);
        chk("R1 ipl", int'(ipl), 0);
        chk("R1 handler_start", int'(handler_start), 0);
    endtask

    task automatic t_idle_done;
        int hits;
        hits = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); instr_done = 1'b1;
            @(negedge clk); instr_done = 1'b0;
            if (busy || handler_start) hits++;
        end
        chk("R3 instr_done ignored while idle", hits, 0);
        chk("R10 ipl untouched while idle", int'(ipl), model_ipl);
    endtask

    task automatic t_sweep;
        int lvl;
        lvl = 1;
        for (int nar = 0; nar < 2; nar++)
            for (int vo = 0; vo < 2; vo++)
                for (int so = 0; so < 2; so++)
                    for (int cls = 0; cls < 3; cls++)
                        for (int sub = 0; sub < 4; sub++) begin
                            run_case(cls, sub, lvl, vo, so, nar, (sub * 3 + cls) % 5, 1'b0,
                                     "sweep");
                            lvl = (lvl % 6) + 1;
                        end
    endtask

    task automatic t_long_wait;
        run_case(0, 0, 5, 1, 0, 0, 30, 1'b0, "R3 divide-length wait");
        run_case(2, 3, 2, 1, 1, 0, 34, 1'b0, "R6 debug after long wait");
    endtask

    task automatic t_disturb;
        run_case(0, 0, 3, 0, 0, 0, 6, 1'b1, "R11 held maskable");
        run_case(2, 1, 6, 1, 1, 1, 5, 1'b1, "R2 ignored while busy");
        run_case(1, 2, 0, 0, 1, 0, 4, 1'b1, "R11 held urgent");
        run_case(2, 0, 4, 0, 0, 0, 3, 1'b1, "R10 quiet keeps level");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_done();
        run_case(0, 3, 4, 0, 0, 0, 0, 1'b0, "R6 sub ignored for maskable");
        run_case(2, 0, 1, 0, 0, 0, 2, 1'b0, "R10 quiet software");
        run_case(1, 3, 0, 1, 1, 0, 1, 1'b0, "R9 urgent");
        t_sweep();
        t_long_wait();
        t_disturb();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule